// File: doc/BRIEF.md
# Guarded Programming-Unlock Sequence Detector

This block decides when a non-volatile programming cycle may begin. While the device rests in its idle condition (run level low), it watches single-cycle host writes on a parallel register bus. A host unlocks programming in three steps. First it writes a first key byte to a fixed key address. Next it writes a second key byte to that same address. Last it drives a dedicated program pin high for at least a minimum number of clock cycles.

When the pin drops after a pulse that was wide enough, the block raises a one-cycle start strobe toward the programming controller and returns to its starting step. A bus write between steps, a wrong key or address, a short pulse, or the run level going high each abandon the attempt. No strobe is produced in any of these cases.

The program pin is asynchronous to the clock and is synchronized by two flops before its edges and width are measured. A debug output shows the current step.

Top module: `prog_unlock_detect`

## Requirements
- R1: After reset, `stepView` is 0 and `startPulse` is 0. The step codes are: 0 waiting for key one, 1 waiting for key two, 2 armed, 3 pin high being timed, 4 firing.
- R2: In step 0 with `runLvl` low, a write of data 0x5A to address 0x8FFF moves the block to step 1 on the next clock. Any other write in step 0 leaves it in step 0.
- R3: In step 1, a write of data 0xA5 to address 0x8FFF moves the block to step 2. Any other write (wrong data or wrong address) returns it to step 0.
- R4: Any bus write while in step 2 or step 3 returns the block to step 0, and no start strobe follows.
- R5: `progPin` passes through a two-flop synchronizer. A rising edge of the pin in step 2 shows up as step 3 at the third clock edge after the pin rises. A pin that was already high before step 2 was reached does not count as a pulse.
- R6: When the pin falls after being sampled high on at least `MIN_HIGH_CYC` clock edges, `startPulse` goes high for exactly one cycle (step 4) at the third clock edge after the fall. The block then returns to step 0.
- R7: A pulse sampled high on fewer than `MIN_HIGH_CYC` edges returns the block to step 0 when the pin falls, with no strobe. The width counter saturates at `MIN_HIGH_CYC`, so a long pulse is accepted.
- R8: While `runLvl` is high, the block goes to step 0 on the next clock from any step and no step advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runLvl | input | 1 | High while the device runs; low means idle |
| busWrEn | input | 1 | Host write strobe, one cycle per write |
| busAddr | input | ADDR_W | Host write address |
| busData | input | DATA_W | Host write data |
| progPin | input | 1 | Raw asynchronous program pin |
| startPulse | output | 1 | One-cycle programming start strobe |
| stepView | output | 3 | Current step code (see R1) |

## Verification
A bus write takes effect on `stepView` one clock after it is sampled. A pin edge needs three clocks: two synchronizer flops plus the step register. The bench drives every input on the falling clock edge. It reads the outputs on a later falling edge, after exactly the number of rising edges that the result needs. Strobes are also counted on every falling edge over the whole of each scenario, so an extra strobe is caught as well as a missing one.

// File: rtl/prog_unlock_pkg.sv
package prog_unlock_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_K1 = 3'd0,
    ST_WAIT_K2 = 3'd1,
    ST_ARMED   = 3'd2,
    ST_HIGH    = 3'd3,
    ST_FIRE    = 3'd4
  } unlockStep_t;

  // control -> datapath
  typedef struct packed {
    logic countEn;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic wrAny;
    logic key1Hit;
    logic key2Hit;
    logic pinRise;
    logic pinFall;
    logic widthOk;
  } dpStatus_t;

endpackage

// File: rtl/prog_unlock_datapath.sv
module prog_unlock_datapath
  import prog_unlock_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 16'h8FFF,
  parameter logic [DATA_W-1:0] KEY_ONE  = 8'h5A,
  parameter logic [DATA_W-1:0] KEY_TWO  = 8'hA5,
  parameter int MIN_HIGH_CYC = 200000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              progPin,
  input  ctlStrobe_t        ctl,
  output dpStatus_t         status
);

  localparam int CNT_W = $clog2(MIN_HIGH_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_HIGH_CYC);

  logic [2:0]       pinPipe;   // [0],[1] synchronizer, [2] edge history
  logic [CNT_W-1:0] highCnt;
  logic             pinSync;

  assign pinSync = pinPipe[1];

  always_ff @(posedge clk) begin
    if (!rstN) pinPipe <= '0;
    else       pinPipe <= {pinPipe[1:0], progPin};
  end

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.countEn || !pinSync) highCnt <= '0;
    else if (highCnt != CNT_MAX)           highCnt <= highCnt + CNT_W'(1);
  end

  always_comb begin
    status.wrAny   = busWrEn;
    status.key1Hit = busWrEn && (busAddr == KEY_ADDR) && (busData == KEY_ONE);
    status.key2Hit = busWrEn && (busAddr == KEY_ADDR) && (busData == KEY_TWO);
    status.pinRise = pinSync && !pinPipe[2];
    status.pinFall = !pinSync && pinPipe[2];
    status.widthOk = (highCnt == CNT_MAX);
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    highCnt <= CNT_MAX);

  assert_count_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.countEn |=> highCnt == '0);

endmodule

// File: rtl/prog_unlock_control.sv
module prog_unlock_control
  import prog_unlock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runLvl,
  input  dpStatus_t   status,
  output ctlStrobe_t  ctl,
  output unlockStep_t step
);

  unlockStep_t stepNxt;

  always_comb begin
    stepNxt = step;
    if (runLvl) stepNxt = ST_WAIT_K1;
    else begin
      unique case (step)
        ST_WAIT_K1: if (status.key1Hit) stepNxt = ST_WAIT_K2;
        ST_WAIT_K2: if (status.wrAny)
                      stepNxt = status.key2Hit ? ST_ARMED : ST_WAIT_K1;
        ST_ARMED:   if (status.wrAny)        stepNxt = ST_WAIT_K1;
                    else if (status.pinRise) stepNxt = ST_HIGH;
        ST_HIGH:    if (status.wrAny)        stepNxt = ST_WAIT_K1;
                    else if (status.pinFall)
                      stepNxt = status.widthOk ? ST_FIRE : ST_WAIT_K1;
        ST_FIRE:    stepNxt = ST_WAIT_K1;
        default:    stepNxt = ST_WAIT_K1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) step <= ST_WAIT_K1;
    else       step <= stepNxt;
  end

  assign ctl.countEn = (step == ST_ARMED) || (step == ST_HIGH);

  assert_run_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    runLvl |=> step == ST_WAIT_K1);

  assert_arm_after_key1_R3: assert property (@(posedge clk) disable iff (!rstN)
    (step == ST_ARMED && $past(step) != ST_ARMED) |-> $past(step) == ST_WAIT_K2);

  assert_write_aborts_R4: assert property (@(posedge clk) disable iff (!rstN)
    (status.wrAny && !runLvl && (step == ST_ARMED || step == ST_HIGH))
      |=> step == ST_WAIT_K1);

  assert_fire_from_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (step == ST_FIRE) |-> $past(step) == ST_HIGH);

  assert_fire_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    (step == ST_FIRE) |=> step == ST_WAIT_K1);

endmodule

// File: rtl/prog_unlock_detect.sv
module prog_unlock_detect
  import prog_unlock_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 16'h8FFF,
  parameter logic [DATA_W-1:0] KEY_ONE  = 8'h5A,
  parameter logic [DATA_W-1:0] KEY_TWO  = 8'hA5,
  parameter int MIN_HIGH_CYC = 200000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runLvl,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              progPin,
  output logic              startPulse,
  output logic [2:0]        stepView
);

  ctlStrobe_t  ctl;
  dpStatus_t   status;
  unlockStep_t step;

  prog_unlock_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
    .KEY_ONE(KEY_ONE), .KEY_TWO(KEY_TWO), .MIN_HIGH_CYC(MIN_HIGH_CYC)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busData(busData), .progPin(progPin), .ctl(ctl), .status(status)
  );

  prog_unlock_control i_control (
    .clk(clk), .rstN(rstN), .runLvl(runLvl), .status(status),
    .ctl(ctl), .step(step)
  );

  assign startPulse = (step == ST_FIRE);
  assign stepView   = step;

  assert_strobe_one_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

endmodule

// File: tb/test_prog_unlock_detect.sv
`timescale 1ns/1ps
module test_prog_unlock_detect;

  localparam int MIN = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        runLvl;
  logic        busWrEn;
  logic [15:0] busAddr;
  logic [7:0]  busData;
  logic        progPin;
  logic        startPulse;
  logic [2:0]  stepView;

  int checks = 0;
  int failures = 0;
  int strobes = 0;

  always #2.5 clk = ~clk;

  prog_unlock_detect #(.MIN_HIGH_CYC(MIN)) i_prog_unlock_detect (
    .clk(clk), .rstN(rstN), .runLvl(runLvl), .busWrEn(busWrEn),
    .busAddr(busAddr), .busData(busData), .progPin(progPin),
    .startPulse(startPulse), .stepView(stepView)
  );

  typedef struct packed {
    logic [7:0]  k1;
    logic [7:0]  k2;
    logic [15:0] k2Addr;
    logic        stray;
    logic [7:0]  len;
    logic        expFire;
  } scen_t;

  localparam scen_t SCN [7] = '{
    '{8'h5A, 8'hA5, 16'h8FFF, 1'b0, 8'd8,  1'b1},  // R6 exact minimum
    '{8'h5A, 8'hA5, 16'h8FFF, 1'b0, 8'd7,  1'b0},  // R7 one short
    '{8'h5A, 8'hA5, 16'h8FFF, 1'b0, 8'd20, 1'b1},  // R7 saturating long pulse
    '{8'hA5, 8'h5A, 16'h8FFF, 1'b0, 8'd8,  1'b0},  // R2 swapped keys
    '{8'h5A, 8'h5A, 16'h8FFF, 1'b0, 8'd8,  1'b0},  // R3 wrong second key
    '{8'h5A, 8'hA5, 16'h8FFE, 1'b0, 8'd8,  1'b0},  // R3 wrong address
    '{8'h5A, 8'hA5, 16'h8FFF, 1'b1, 8'd8,  1'b0}   // R4 stray write when armed
  };

  task automatic tick();
    @(negedge clk);
    if (startPulse) strobes++;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    busWrEn = 1'b1; busAddr = a; busData = d;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic runBlip();
    runLvl = 1'b1; tick(); runLvl = 1'b0; tick();
  endtask

  task automatic pulse(input int len);
    progPin = 1'b1;
    repeat (len) tick();
    progPin = 1'b0;
  endtask

  initial begin
    #500000;
    checks++; failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; runLvl = 1'b0; busWrEn = 1'b0; busAddr = '0; busData = '0;
    progPin = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset step", stepView, 0);
    chk("R1 reset strobe", startPulse, 0);

    // Scenario table
    foreach (SCN[i]) begin
      runBlip();
      strobes = 0;
      wr(16'h8FFF, SCN[i].k1);
      wr(SCN[i].k2Addr, SCN[i].k2);
      if (SCN[i].stray) wr(16'h1234, 8'h00);
      tick();
      pulse(SCN[i].len);
      repeat (6) tick();
      chk($sformatf("R6/R7 scenario %0d strobes", i), strobes, int'(SCN[i].expFire));
    end

    // R2/R3/R5/R6: step progression and exact timing
    runBlip();
    strobes = 0;
    wr(16'h0100, 8'h5A);
    chk("R2 other write ignored", stepView, 0);
    wr(16'h8FFF, 8'h5A);
    chk("R2 key one", stepView, 1);
    wr(16'h8FFF, 8'hA5);
    chk("R3 key two", stepView, 2);
    progPin = 1'b1;
    tick(); tick();
    chk("R5 two edges not yet", stepView, 2);
    tick();
    chk("R5 rise seen third edge", stepView, 3);
    repeat (MIN) tick();
    progPin = 1'b0;
    tick(); tick();
    chk("R6 no strobe before third edge", startPulse, 0);
    tick();
    chk("R6 strobe on third edge", startPulse, 1);
    chk("R6 fire step", stepView, 4);
    tick();
    chk("R6 strobe ends", startPulse, 0);
    chk("R6 back to step 0", stepView, 0);

    // R3: stray write between keys
    wr(16'h8FFF, 8'h5A);
    wr(16'h2000, 8'hA5);
    chk("R3 stray between keys", stepView, 0);

    // R4: write while pin high
    strobes = 0;
    wr(16'h8FFF, 8'h5A);
    wr(16'h8FFF, 8'hA5);
    progPin = 1'b1;
    repeat (4) tick();
    chk("R4 timing step", stepView, 3);
    wr(16'h0000, 8'h00);
    chk("R4 write in step 3", stepView, 0);
    repeat (MIN) tick();
    progPin = 1'b0;
    repeat (5) tick();
    chk("R4 no strobe", strobes, 0);

    // R5: pin already high before arming
    progPin = 1'b1;
    repeat (3) tick();
    wr(16'h8FFF, 8'h5A);
    wr(16'h8FFF, 8'hA5);
    repeat (MIN + 2) tick();
    progPin = 1'b0;
    repeat (5) tick();
    chk("R5 early pin stays armed", stepView, 2);
    chk("R5 early pin no strobe", strobes, 0);

    // R8: run high stops progress and clears
    runBlip();
    runLvl = 1'b1;
    wr(16'h8FFF, 8'h5A);
    chk("R8 no advance while running", stepView, 0);
    runLvl = 1'b0;
    wr(16'h8FFF, 8'h5A);
    wr(16'h8FFF, 8'hA5);
    progPin = 1'b1;
    repeat (4) tick();
    runLvl = 1'b1;
    tick();
    chk("R8 run clears step 3", stepView, 0);
    runLvl = 1'b0;
    repeat (MIN) tick();
    progPin = 1'b0;
    repeat (5) tick();
    chk("R8 no strobe after run", strobes, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule